// File: doc/BRIEF.md
# Interpolation Window Reuse Scheduler

This block orders the reference fetches for the sixteen 4x4 luma blocks of one macroblock. Each 4x4 block needs a 9x9 window of reference pixels for fractional interpolation. When a block has the same motion vector as the block to its immediate left, the two windows overlap in a 5-column by 9-row region. In that case the block only needs its 4 new columns, 36 pixels, instead of all 81.

Blocks are issued in the same 2x2-of-2x2 raster order that the residual decoder uses. To keep a left neighbour's window available across a quadrant boundary, the scheduler pulses a swap strobe at fixed positions in that order. The strobe tells the interpolator to exchange its local window registers with a one-window content buffer. The content buffer, the frame memory and the interpolator are outside this block.

A macroblock run starts with a start pulse, which also captures the sixteen vectors. Each block's fetch request is offered on a valid/ready channel. Once a request is accepted, the scheduler waits for a fetch-done pulse before it moves on to the next block. During the run it adds up the pixels requested and flags the end of the macroblock.

Back-pressure rule: a request stays offered, unchanged, for as long as `req_ready` is low. It is consumed in the first cycle in which `req_valid` and `req_ready` are both high. No output depends combinationally on any input.

Top module: `win_reuse_sched`

## Requirements
- R1: During and after reset, `busy`, `req_valid`, `swap_stb` and `mb_done` are 0 and `pix_total` is 0.
- R2: A `start` pulse while idle captures `mv_flat` and raises `busy`. `busy` stays high until the cycle after `mb_done`. A `start` while busy is ignored, and so is any change of `mv_flat` after capture.
- R3: Blocks are requested in ascending index 0..15. Block b lies in quadrant b/4 and at sub-position b%4, where both levels are counted in raster order (top-left, top-right, bottom-left, bottom-right). Its column is x = 2*((b/4)%2) + (b%2).
- R4: A block with no left neighbour inside the macroblock (column 0: blocks 0, 2, 8, 10) always requests a full window: `req_full`=1, `req_pix`=81.
- R5: Every other block compares its vector with its left neighbour's. The left neighbour is b-1 for odd b and b-3 for blocks 4, 6, 12 and 14. If the whole 2*MVW-bit vector words match (x in the low half, y in the high half), the block requests a partial window (`req_full`=0, `req_pix`=36); otherwise it requests 81.
- R6: `swap_stb` pulses for exactly one cycle, whatever the vectors, in the cycle just before the request of blocks 2, 4, 6, 10, 12 and 14. It never pulses at any other time and never while `req_valid` is high.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_blk`, `req_full` and `req_pix` hold their values.
- R8: After a request is accepted, no request and no swap occur until a `fetch_done` pulse arrives. `fetch_done` at any other time is ignored.
- R9: `pix_total` is cleared at start and adds `req_pix` on each acceptance. `mb_done` pulses for one cycle, the cycle after the sixteenth `fetch_done`, and `pix_total` then holds the macroblock total until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a macroblock; captures vectors when idle |
| mv_flat | input | NBLK*2*MVW | Block b vector at bits [b*2*MVW +: 2*MVW], x low, y high |
| busy | output | 1 | Macroblock run in progress |
| swap_stb | output | 1 | Exchange interpolator registers with content buffer |
| req_valid | output | 1 | Fetch request offered |
| req_ready | input | 1 | Fetch request accepted when high with req_valid |
| req_blk | output | IDXW | Block index of the request |
| req_full | output | 1 | 1: full window, 0: new columns only |
| req_pix | output | PIXW | Pixels requested (81 or 36) |
| fetch_done | input | 1 | Pulse: the accepted fetch has finished |
| mb_done | output | 1 | Pulse: macroblock finished |
| pix_total | output | TOTW | Pixels requested in the current macroblock |

## Verification
On every cycle, the assertions check four things:
- requests hold steady under back-pressure;
- a swap strobe never coincides with a request and is always followed by one;
- nothing is issued while a fetch is outstanding;
- accepted block indices advance by one, wrapping after the last block, and each request's pixel count matches its full/partial flag, with block 0 always full.

Only the bench's scenarios can show the following:
- whether the full/partial choice is right for a given set of vectors, including vectors that differ in only one component;
- that swaps fall at the right positions;
- that the per-macroblock pixel totals come out right;
- that a start or a vector change arriving mid-run leaves the result unaffected.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWAP,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } wrs_state_e;

  // side length of the interpolation window for a block edge and filter length
  function automatic int win_side(input int blk_edge, input int taps);
    return blk_edge + taps - 1;
  endfunction

endpackage

// File: rtl/wrs_nbr.sv
// Positional neighbour map for the 2x2-of-2x2 block order.
module wrs_nbr #(
  parameter int GRID = 4,
  parameter int NBLK = GRID * GRID,
  parameter int IDXW = $clog2(NBLK)
) (
  output logic [NBLK-1:0]      has_pred,
  output logic [NBLK*IDXW-1:0] pred_idx,
  output logic [NBLK-1:0]      swap_pt
);

  localparam int QPR = GRID / 2;   // quadrants per row

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    localparam int SUB  = b % 4;
    localparam int QUAD = b / 4;
    localparam int QX   = QUAD % QPR;
    localparam bit ODD  = (SUB % 2) == 1;
    localparam int PRED = ODD ? (b - 1) : ((QX > 0) ? (b - 3) : b);
    localparam logic [31:0] PRED_V = PRED;

    assign has_pred[b] = ODD || (QX > 0);
    assign pred_idx[b*IDXW +: IDXW] = PRED_V[IDXW-1:0];
    // save the upper-right window before the lower row starts; restore across quadrants
    assign swap_pt[b] = (SUB == 2) || ((SUB == 0) && (QX > 0));
  end

endmodule

// File: rtl/wrs_cmp.sv
// Selects two captured vectors and reports equality of the full word.
module wrs_cmp #(
  parameter int NBLK = 16,
  parameter int IDXW = 4,
  parameter int VW   = 16
) (
  input  logic [NBLK*VW-1:0] mv_words,
  input  logic [IDXW-1:0]    cur_idx,
  input  logic [IDXW-1:0]    prd_idx,
  output logic               same
);

  logic [VW-1:0] cur_mv;
  logic [VW-1:0] prd_mv;

  always_comb begin
    cur_mv = mv_words[int'(cur_idx)*VW +: VW];
    prd_mv = mv_words[int'(prd_idx)*VW +: VW];
    same   = (cur_mv == prd_mv);
  end

endmodule

// File: rtl/wrs_acc.sv
// Per-macroblock pixel accumulator.
module wrs_acc #(
  parameter int PIXW = 7,
  parameter int TOTW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            add_en,
  input  logic [PIXW-1:0] add_val,
  output logic [TOTW-1:0] total
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      total <= '0;
    end else if (add_en) begin
      total <= total + TOTW'(add_val);
    end
  end

endmodule

// File: rtl/win_reuse_sched.sv
module win_reuse_sched
  import wrs_pkg::*;
#(
  parameter int GRID = 4,
  parameter int MVW  = 8,
  parameter int BLK  = 4,
  parameter int TAPS = 6,
  localparam int NBLK     = GRID * GRID,
  localparam int IDXW     = $clog2(NBLK),
  localparam int VW       = 2 * MVW,
  localparam int WIN      = win_side(BLK, TAPS),
  localparam int FULL_PIX = WIN * WIN,
  localparam int PART_PIX = BLK * WIN,
  localparam int PIXW     = $clog2(FULL_PIX + 1),
  localparam int TOTW     = $clog2(NBLK * FULL_PIX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NBLK*VW-1:0]   mv_flat,
  output logic                 busy,
  output logic                 swap_stb,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [IDXW-1:0]      req_blk,
  output logic                 req_full,
  output logic [PIXW-1:0]      req_pix,
  input  logic                 fetch_done,
  output logic                 mb_done,
  output logic [TOTW-1:0]      pix_total
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NBLK - 1);
  localparam logic [PIXW-1:0] FULL_V   = PIXW'(FULL_PIX);
  localparam logic [PIXW-1:0] PART_V   = PIXW'(PART_PIX);

  wrs_state_e           state;
  logic [IDXW-1:0]      idx;
  logic [NBLK*VW-1:0]   mv_q;
  logic [NBLK-1:0]      has_pred;
  logic [NBLK*IDXW-1:0] pred_map;
  logic [NBLK-1:0]      swap_pt;
  logic [IDXW-1:0]      cur_pred;
  logic [IDXW-1:0]      nxt_idx;
  logic                 vec_same;
  logic                 accept;
  logic                 launch;

  wrs_nbr #(.GRID(GRID), .NBLK(NBLK), .IDXW(IDXW)) u_nbr (
    .has_pred (has_pred),
    .pred_idx (pred_map),
    .swap_pt  (swap_pt)
  );

  assign cur_pred = pred_map[int'(idx)*IDXW +: IDXW];
  assign nxt_idx  = idx + 1'b1;

  wrs_cmp #(.NBLK(NBLK), .IDXW(IDXW), .VW(VW)) u_cmp (
    .mv_words (mv_q),
    .cur_idx  (idx),
    .prd_idx  (cur_pred),
    .same     (vec_same)
  );

  assign launch = (state == ST_IDLE) && start;
  assign accept = (state == ST_REQ) && req_ready;

  wrs_acc #(.PIXW(PIXW), .TOTW(TOTW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch),
    .add_en  (accept),
    .add_val (req_pix),
    .total   (pix_total)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      mv_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mv_q  <= mv_flat;
            idx   <= '0;
            state <= swap_pt[0] ? ST_SWAP : ST_REQ;
          end
        end
        ST_SWAP: state <= ST_REQ;
        ST_REQ: begin
          if (req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fetch_done) begin
            if (idx == LAST_IDX) begin
              state <= ST_DONE;
            end else begin
              idx   <= nxt_idx;
              state <= swap_pt[nxt_idx] ? ST_SWAP : ST_REQ;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    swap_stb  = (state == ST_SWAP);
    req_valid = (state == ST_REQ);
    mb_done   = (state == ST_DONE);
    req_blk   = idx;
    req_full  = !(has_pred[idx] && vec_same);
    req_pix   = req_full ? FULL_V : PART_V;
  end

endmodule

// File: rtl/wrs_chk.sv
module wrs_chk #(
  parameter int NBLK     = 16,
  parameter int IDXW     = 4,
  parameter int PIXW     = 7,
  parameter int TOTW     = 11,
  parameter int FULL_PIX = 81,
  parameter int PART_PIX = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            swap_stb,
  input logic            req_valid,
  input logic            req_ready,
  input logic [IDXW-1:0] req_blk,
  input logic            req_full,
  input logic [PIXW-1:0] req_pix,
  input logic            fetch_done,
  input logic            mb_done,
  input logic [TOTW-1:0] pix_total
);

  logic            pending;
  logic [IDXW-1:0] want_blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      want_blk <= '0;
    end else if (req_valid && req_ready) begin
      pending  <= 1'b1;
      want_blk <= (want_blk == IDXW'(NBLK - 1)) ? '0 : want_blk + 1'b1;
    end else if (fetch_done) begin
      pending <= 1'b0;
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_blk) && $stable(req_full) && $stable(req_pix)));

  // R6
  swap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_stb |-> !req_valid);

  // R6
  swap_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_stb |=> (req_valid && !swap_stb));

  // R8
  no_issue_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (!req_valid && !swap_stb));

  // R3
  blk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (req_blk == want_blk));

  // R4
  first_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_blk == '0) |-> req_full);

  // R5
  pix_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_full ? (req_pix == PIXW'(FULL_PIX)) : (req_pix == PIXW'(PART_PIX))));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_done |=> (!mb_done && !busy));

  // R9
  total_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_done |-> (pix_total >= TOTW'(NBLK * PART_PIX) && pix_total <= TOTW'(NBLK * FULL_PIX)));

endmodule

bind win_reuse_sched wrs_chk #(
  .NBLK(NBLK), .IDXW(IDXW), .PIXW(PIXW), .TOTW(TOTW),
  .FULL_PIX(FULL_PIX), .PART_PIX(PART_PIX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .swap_stb(swap_stb),
  .req_valid(req_valid), .req_ready(req_ready), .req_blk(req_blk),
  .req_full(req_full), .req_pix(req_pix), .fetch_done(fetch_done),
  .mb_done(mb_done), .pix_total(pix_total)
);

// File: tb/win_reuse_sched_test.sv
module win_reuse_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req_ready = 1'b0;
  logic fetch_done = 1'b0;
  logic [NB*16-1:0] mv_flat;
  logic [15:0] tv [NB];
  logic busy, swap_stb, req_valid, req_full, mb_done;
  logic [3:0] req_blk;
  logic [6:0] req_pix;
  logic [10:0] pix_total;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int b = 0; b < NB; b++) mv_flat[b*16 +: 16] = tv[b];

  win_reuse_sched uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mv_flat(mv_flat),
    .busy(busy), .swap_stb(swap_stb), .req_valid(req_valid),
    .req_ready(req_ready), .req_blk(req_blk), .req_full(req_full),
    .req_pix(req_pix), .fetch_done(fetch_done), .mb_done(mb_done),
    .pix_total(pix_total)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  localparam int P_IDLE = 0, P_SWAP = 1, P_REQ = 2, P_WAIT = 3, P_DONE = 4;
  int ph = P_IDLE;
  int m_idx = 0;
  int m_tot = 0;
  bit done_seen = 0;
  logic [15:0] mvm [NB];

  function automatic int col_of(input int b);
    return 2 * ((b / 4) % 2) + (b % 2);
  endfunction
  function automatic int row_of(input int b);
    return 2 * (b / 8) + ((b % 4) / 2);
  endfunction
  function automatic int left_of(input int b);
    for (int k = 0; k < NB; k++)
      if (col_of(k) == col_of(b) - 1 && row_of(k) == row_of(b)) return k;
    return -1;
  endfunction
  function automatic bit full_of(input int b, input logic [15:0] v [NB]);
    int l;
    l = left_of(b);
    if (l < 0) return 1'b1;
    return v[b] != v[l];
  endfunction
  function automatic bit swap_of(input int b);
    return (b % 4 == 2) || ((b % 4 == 0) && col_of(b) != 0);
  endfunction
  function automatic int mb_total(input logic [15:0] v [NB]);
    int s;
    s = 0;
    for (int b = 0; b < NB; b++) s += full_of(b, v) ? 81 : 36;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = P_IDLE; m_idx = 0; m_tot = 0;
    end else begin
      case (ph)
        P_IDLE: if (start) begin
          for (int b = 0; b < NB; b++) mvm[b] = tv[b];
          m_idx = 0; m_tot = 0;
          ph = swap_of(0) ? P_SWAP : P_REQ;
        end
        P_SWAP: ph = P_REQ;
        P_REQ: if (req_ready) begin
          m_tot += full_of(m_idx, mvm) ? 81 : 36;
          ph = P_WAIT;
        end
        P_WAIT: if (fetch_done) begin
          if (m_idx == NB - 1) ph = P_DONE;
          else begin
            m_idx++;
            ph = swap_of(m_idx) ? P_SWAP : P_REQ;
          end
        end
        default: begin ph = P_IDLE; done_seen = 1; end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(ph == P_WAIT ? "R8 req_valid while waiting" : "R7 req_valid", int'(req_valid), int'(ph == P_REQ));
      if (ph == P_REQ && req_valid) begin
        check("R3 req_blk", int'(req_blk), m_idx);
        check(left_of(m_idx) < 0 ? "R4 req_full" : "R5 req_full", int'(req_full), int'(full_of(m_idx, mvm)));
        check("R5 req_pix", int'(req_pix), full_of(m_idx, mvm) ? 81 : 36);
      end
      check("R6 swap_stb", int'(swap_stb), int'(ph == P_SWAP));
      check("R9 mb_done", int'(mb_done), int'(ph == P_DONE));
      check("R2 busy", int'(busy), int'(ph != P_IDLE));
      check("R9 pix_total", int'(pix_total), m_tot);
    end
    if (mode == 0) begin
      req_ready <= 1'b1; fetch_done <= 1'b1;
    end else begin
      req_ready  <= lfsr[0] | lfsr[3];
      fetch_done <= lfsr[5] & lfsr[8];
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired expected=mb_done actual=hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_mb();
    while (!done_seen) @(negedge clk);
    done_seen = 0;
  endtask

  task automatic run_mb(input int md, input int exp_tot, input bit disturb);
    mode = md;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (disturb) begin
      repeat (6) @(negedge clk);
      for (int b = 0; b < NB; b++) tv[b] = 16'h7777;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_mb();
    check("R9 macroblock total", int'(pix_total), exp_tot);
    @(negedge clk);
    check("R9 total held after done", int'(pix_total), exp_tot);
  endtask

  initial begin
    int e;
    for (int b = 0; b < NB; b++) tv[b] = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 req_valid in reset", int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 swap_stb after reset", int'(swap_stb), 0);
    check("R1 mb_done after reset", int'(mb_done), 0);
    check("R1 pix_total after reset", int'(pix_total), 0);

    // all vectors equal: 4 full + 12 partial
    for (int b = 0; b < NB; b++) tv[b] = 16'h0305;
    run_mb(0, 756, 0);

    // all distinct: every block full
    for (int b = 0; b < NB; b++) tv[b] = 16'(b * 16'h0111 + 1);
    run_mb(0, 1296, 0);

    // only block 4 matches its left neighbour (block 1), across quadrants
    for (int b = 0; b < NB; b++) tv[b] = 16'(b * 16'h0111 + 1);
    tv[4] = tv[1];
    run_mb(1, 1251, 0);

    // single-component differences stay full; 5 matches 4
    for (int b = 0; b < NB; b++) tv[b] = 16'(b * 16'h0111 + 1);
    tv[1] = tv[0] ^ 16'h0100;
    tv[3] = tv[2] ^ 16'h0001;
    tv[5] = tv[4];
    run_mb(1, 1251, 0);

    // mixed pattern under back-pressure
    for (int b = 0; b < NB; b++) tv[b] = 16'((b % 3 == 0) ? 16'h0101 : 16'h0202);
    e = mb_total(tv);
    run_mb(1, e, 0);

    // start and vector change while busy are ignored (R2)
    for (int b = 0; b < NB; b++) tv[b] = 16'(b * 16'h0111 + 1);
    run_mb(0, 1296, 1);

    // a few more patterns with random handshakes
    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < NB; b++) tv[b] = 16'((lfsr ^ 16'(b * 7)) & 16'h0303);
      e = mb_total(tv);
      run_mb(1, e, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule